// File: doc/BRIEF.md
# Sample Output Formatter with Test Patterns

This block sits between a data converter core and a parallel output bus. Every sample clock it accepts one raw sample in offset-binary form. It re-codes that sample into one of three number codings and drives the result on a registered output word. For in-system testing, a pattern source can take the place of live samples. The pattern source offers a small set of fixed patterns, or a cycling sequence of user-loaded 16-bit words.

All settings arrive through a byte-wide register write port that runs on a separate control clock. The coding selection survives a soft reset. The test-mode controls and the user pattern table do not. Control fields cross into the sample domain through a two-stage synchronizer. Because of that, a new setting shows up at the output a few sample cycles after the write, not at a fixed edge.

Top module: `sof_formatter`

## Requirements
- R1: With coding field 3'b000 the output is the sample with its MSB inverted (two's complement). With 3'b010 it is sample XOR (sample >> 1) (Gray). With 3'b100 it is the sample unchanged (offset binary). A sample presented before a sample-clock rising edge appears on `data_out` right after that edge.
- R2: Coding codes other than 000, 010 and 100 produce the two's complement coding.
- R3: While `smp_rst_n` is low, `data_out` is zero. A power-on reset (`cfg_rst_n` low) returns the coding field to 000 and switches all test modes off.
- R4: A `soft_rst` pulse leaves the coding field unchanged. It clears both test-mode fields and all user pattern words to zero.
- R5: Write map. Address 0x00 bits 2:0 hold the coding field. Address 0x01 bits 7:4 hold the preset test field and bits 2:0 hold the user test field. User pattern k (k = 1..8) takes its low byte at address 0x10 + 2(k-1) and its high byte at the next address.
- R6: Preset field codes. 1 gives all zeros. 2 gives all ones. 3 gives words that alternate between 0xAAAA and 0x5555 on every sample. 4 gives a ramp that rises by one per sample and wraps. Codes 5 to 15 give all zeros. Code 0 selects no preset.
- R7: With the preset field at 0 and a user field value N from 1 to 7, the output repeats user patterns 1, 2, ..., N in order, one per sample. N = 0 means live data.
- R8: A nonzero preset field takes priority over the user field.
- R9: Test pattern words reach `data_out` without passing through the coding stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Control-domain clock |
| cfg_rst_n | input | 1 | Power-on reset for the control registers, active low, asynchronous |
| soft_rst | input | 1 | Synchronous soft reset in the control domain, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 8 | Register write data |
| smp_clk | input | 1 | Sample clock |
| smp_rst_n | input | 1 | Sample-domain reset, active low, asynchronous |
| sample_in | input | 16 | Raw offset-binary sample |
| data_out | output | 16 | Registered formatted sample or test word |

## Verification
The bench aims at the coding boundaries. It uses samples at midscale, zero and full scale, where a design with the wrong MSB handling or shift direction gives a visibly wrong word. It also drives the unlisted coding codes, which a careless decoder would pass through unchanged. It loads user patterns byte by byte and runs N = 1, 3 and 7 to catch swapped bytes, an off-by-one wrap or a stuck index. A preset field applied together with a user field exposes a wrong priority. A soft reset applied with Gray coding active shows whether the coding field was wrongly cleared and whether the pattern table was wrongly kept.

// File: rtl/sof_pkg.sv
`timescale 1ns/1ps
package sof_pkg;

   // coding field codes
   localparam int          FMT_W    = 3;
   localparam logic [2:0]  FMT_TWOS = 3'b000;
   localparam logic [2:0]  FMT_GRAY = 3'b010;
   localparam logic [2:0]  FMT_OBIN = 3'b100;

   // preset test field codes
   localparam int          PRE_W    = 4;
   localparam logic [3:0]  PRE_OFF  = 4'd0;
   localparam logic [3:0]  PRE_ZERO = 4'd1;
   localparam logic [3:0]  PRE_ONES = 4'd2;
   localparam logic [3:0]  PRE_ALT  = 4'd3;
   localparam logic [3:0]  PRE_RAMP = 4'd4;

   // user test field
   localparam int          USR_W    = 3;

   typedef struct packed {
      logic [PRE_W-1:0] preset;
      logic [USR_W-1:0] user;
      logic [FMT_W-1:0] fmt;
   } sof_ctrl_t;

endpackage

// File: rtl/sof_sync.sv
`timescale 1ns/1ps
module sof_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   localparam int CHAIN_W = WIDTH * STAGES;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sof_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
   end

   assign q = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/sof_cfg_regs.sv
`timescale 1ns/1ps
module sof_cfg_regs
   import sof_pkg::*;
#(
   parameter int                DATA_W    = 16,
   parameter int                PAT_DEPTH = 8,
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] FMT_ADDR  = 'h00,
   parameter logic [ADDR_W-1:0] TEST_ADDR = 'h01,
   parameter logic [ADDR_W-1:0] PAT_BASE  = 'h10
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             soft_rst,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [7:0]                       wr_data,
   output sof_ctrl_t                        ctrl,
   output logic [PAT_DEPTH-1:0][DATA_W-1:0] pat_tbl
);

   localparam int BYTES  = DATA_W / 8;
   localparam int BSEL_W = (BYTES > 1) ? $clog2(BYTES) : 1;
   localparam int IDX_W  = (PAT_DEPTH > 1) ? $clog2(PAT_DEPTH) : 1;
   localparam int SPAN   = PAT_DEPTH * BYTES;

   generate
      if ((DATA_W % 8) != 0 || BYTES < 2 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_width
         $error("sof_cfg_regs: DATA_W must be a power-of-two count of bytes, at least two");
      end
      if (PAT_DEPTH < 2 || (PAT_DEPTH & (PAT_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sof_cfg_regs: PAT_DEPTH must be a power of two, at least two");
      end
      if ((int'(PAT_BASE) % SPAN) != 0 || int'(PAT_BASE) + SPAN > (1 << ADDR_W)) begin : g_bad_base
         $error("sof_cfg_regs: pattern window misaligned or outside the address space");
      end
   endgenerate

   logic [FMT_W-1:0]               fmt_q;
   logic [PRE_W-1:0]               pre_q;
   logic [USR_W-1:0]               usr_q;
   logic [PAT_DEPTH-1:0][DATA_W-1:0] pat_q;

   logic [ADDR_W-1:0] off;
   logic              wr_ok;
   logic              pat_hit;
   logic [IDX_W-1:0]  ent;
   logic [BSEL_W-1:0] bsel;

   assign wr_ok   = wr_en && !soft_rst;
   assign off     = wr_addr - PAT_BASE;
   assign pat_hit = wr_ok && (wr_addr >= PAT_BASE) && (off < ADDR_W'(SPAN));
   assign bsel    = off[BSEL_W-1:0];
   assign ent     = off[BSEL_W +: IDX_W];

   // coding field: only the power-on reset touches it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           fmt_q <= FMT_TWOS;
      else if (wr_ok && wr_addr == FMT_ADDR) fmt_q <= wr_data[FMT_W-1:0];
   end

   // test control fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         usr_q <= '0;
      end else if (soft_rst) begin
         pre_q <= '0;
         usr_q <= '0;
      end else if (wr_en && wr_addr == TEST_ADDR) begin
         pre_q <= wr_data[7:4];
         usr_q <= wr_data[USR_W-1:0];
      end
   end

   // user pattern table, one byte per write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pat_q <= '0;
      else if (soft_rst) pat_q <= '0;
      else if (pat_hit) pat_q[ent][{bsel, 3'b000} +: 8] <= wr_data;
   end

   assign ctrl.fmt    = fmt_q;
   assign ctrl.preset = pre_q;
   assign ctrl.user   = usr_q;
   assign pat_tbl     = pat_q;

   // R4
   fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> fmt_q == $past(fmt_q));

   // R4
   test_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (pre_q == '0 && usr_q == '0 && pat_q == '0));

endmodule

// File: rtl/sof_pat_gen.sv
`timescale 1ns/1ps
module sof_pat_gen
   import sof_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int PAT_DEPTH = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [PRE_W-1:0]                 preset,
   input  logic [USR_W-1:0]                 user,
   input  logic [PAT_DEPTH-1:0][DATA_W-1:0] pat_tbl,
   output logic                             test_on,
   output logic [DATA_W-1:0]                pat_word
);

   localparam int IDX_W = (PAT_DEPTH > 1) ? $clog2(PAT_DEPTH) : 1;
   localparam int CW    = ((IDX_W > USR_W) ? IDX_W : USR_W) + 1;
   localparam logic [DATA_W-1:0] ALT_A = {(DATA_W/2){2'b10}};
   localparam logic [DATA_W-1:0] ALT_B = ~ALT_A;

   generate
      if ((1 << USR_W) - 1 > PAT_DEPTH) begin : g_bad_user
         $error("sof_pat_gen: user field can address beyond the pattern table");
      end
   endgenerate

   logic             ramp_on, alt_on, user_on;
   logic [DATA_W-1:0] ramp_q;
   logic             alt_q;
   logic [IDX_W-1:0] idx_q;
   logic [CW-1:0]    idx_next_x, n_x;

   assign ramp_on = (preset == PRE_RAMP);
   assign alt_on  = (preset == PRE_ALT);
   assign user_on = (preset == PRE_OFF) && (user != '0);
   assign test_on = (preset != PRE_OFF) || (user != '0);

   assign idx_next_x = CW'(idx_q) + CW'(1);
   assign n_x        = CW'(user);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ramp_q <= '0;
      else if (!ramp_on) ramp_q <= '0;
      else               ramp_q <= ramp_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       alt_q <= 1'b0;
      else if (!alt_on) alt_q <= 1'b0;
      else              alt_q <= ~alt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  idx_q <= '0;
      else if (!user_on)           idx_q <= '0;
      else if (idx_next_x >= n_x)  idx_q <= '0;
      else                         idx_q <= idx_q + 1'b1;
   end

   always_comb begin
      case (preset)
         PRE_OFF:  pat_word = user_on ? pat_tbl[idx_q] : '0;
         PRE_ZERO: pat_word = '0;
         PRE_ONES: pat_word = '1;
         PRE_ALT:  pat_word = alt_q ? ALT_B : ALT_A;
         PRE_RAMP: pat_word = ramp_q;
         default:  pat_word = '0;
      endcase
   end

   // R6
   ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_on && $past(ramp_on)) |-> ramp_q == $past(ramp_q) + 1'b1);

   // R6
   alt_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alt_on && $past(alt_on)) |-> alt_q != $past(alt_q));

   // R7
   user_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (user_on && $past(user_on) && $stable(user)) |-> CW'(idx_q) < n_x);

endmodule

// File: rtl/sof_encoder.sv
`timescale 1ns/1ps
module sof_encoder
   import sof_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [FMT_W-1:0]  fmt,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("sof_encoder: DATA_W must be at least 2");
      end
   endgenerate

   always_comb begin
      case (fmt)
         FMT_GRAY: dout = din ^ (din >> 1);
         FMT_OBIN: dout = din;
         default:  dout = {~din[DATA_W-1], din[DATA_W-2:0]};
      endcase
   end

endmodule

// File: rtl/sof_formatter.sv
`timescale 1ns/1ps
module sof_formatter
   import sof_pkg::*;
#(
   parameter int                DATA_W      = 16,
   parameter int                PAT_DEPTH   = 8,
   parameter int                ADDR_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] FMT_ADDR    = 'h00,
   parameter logic [ADDR_W-1:0] TEST_ADDR   = 'h01,
   parameter logic [ADDR_W-1:0] PAT_BASE    = 'h10
) (
   input  logic              cfg_clk,
   input  logic              cfg_rst_n,
   input  logic              soft_rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              smp_clk,
   input  logic              smp_rst_n,
   input  logic [DATA_W-1:0] sample_in,
   output logic [DATA_W-1:0] data_out
);

   localparam int CTRL_W = $bits(sof_ctrl_t);

   sof_ctrl_t                        ctrl_c, ctrl_s;
   logic [CTRL_W-1:0]                ctrl_sv;
   logic [PAT_DEPTH-1:0][DATA_W-1:0] pat_tbl;
   logic                             test_on;
   logic [DATA_W-1:0]                pat_word, enc_word, out_q;

   sof_cfg_regs #(
      .DATA_W(DATA_W), .PAT_DEPTH(PAT_DEPTH), .ADDR_W(ADDR_W),
      .FMT_ADDR(FMT_ADDR), .TEST_ADDR(TEST_ADDR), .PAT_BASE(PAT_BASE)
   ) u_regs (
      .clk(cfg_clk), .rst_n(cfg_rst_n), .soft_rst(soft_rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ctrl(ctrl_c), .pat_tbl(pat_tbl)
   );

   sof_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(smp_clk), .rst_n(smp_rst_n), .d(ctrl_c), .q(ctrl_sv)
   );
   assign ctrl_s = ctrl_sv;

   sof_pat_gen #(.DATA_W(DATA_W), .PAT_DEPTH(PAT_DEPTH)) u_pat (
      .clk(smp_clk), .rst_n(smp_rst_n),
      .preset(ctrl_s.preset), .user(ctrl_s.user), .pat_tbl(pat_tbl),
      .test_on(test_on), .pat_word(pat_word)
   );

   sof_encoder #(.DATA_W(DATA_W)) u_enc (
      .fmt(ctrl_s.fmt), .din(sample_in), .dout(enc_word)
   );

   always_ff @(posedge smp_clk or negedge smp_rst_n) begin
      if (!smp_rst_n)   out_q <= '0;
      else if (test_on) out_q <= pat_word;
      else              out_q <= enc_word;
   end

   assign data_out = out_q;

   // R1
   obin_pass_chk: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
      (!test_on && ctrl_s.fmt == FMT_OBIN) |=> data_out == $past(sample_in));

   // R9
   ones_bypass_chk: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
      (ctrl_s.preset == PRE_ONES) |=> data_out == '1);

   // R8
   preset_first_chk: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
      (ctrl_s.preset == PRE_ZERO && ctrl_s.user != '0) |=> data_out == '0);

endmodule

// File: tb/sof_formatter_test.sv
`timescale 1ns/1ps
module sof_formatter_test;

   logic        cfg_clk = 1'b0, smp_clk = 1'b0;
   logic        cfg_rst_n = 1'b0, smp_rst_n = 1'b0;
   logic        soft_rst = 1'b0, wr_en = 1'b0;
   logic [7:0]  wr_addr = '0, wr_data = '0;
   logic [15:0] sample_in = '0;
   logic [15:0] data_out;

   int total = 0;
   int bad   = 0;

   always #10 smp_clk = ~smp_clk;   // 50 MHz
   always #15 cfg_clk = ~cfg_clk;

   sof_formatter uut (
      .cfg_clk(cfg_clk), .cfg_rst_n(cfg_rst_n), .soft_rst(soft_rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .smp_clk(smp_clk), .smp_rst_n(smp_rst_n),
      .sample_in(sample_in), .data_out(data_out)
   );

   // {coding, sample, expected}
   localparam int NVEC = 12;
   localparam logic [34:0] VEC [NVEC] = '{
      {3'b000, 16'h8000, 16'h0000},
      {3'b000, 16'h0000, 16'h8000},
      {3'b000, 16'h1234, 16'h9234},
      {3'b010, 16'h0000, 16'h0000},
      {3'b010, 16'h0003, 16'h0002},
      {3'b010, 16'hFFFF, 16'h8000},
      {3'b010, 16'h1234, 16'h1B2E},
      {3'b100, 16'h1234, 16'h1234},
      {3'b100, 16'hFFFF, 16'hFFFF},
      {3'b001, 16'h1234, 16'h9234},
      {3'b111, 16'h0001, 16'h8001},
      {3'b110, 16'hFFFF, 16'h7FFF}
   };

   function automatic logic [15:0] pat_val(int k);
      return {8'(8'hC0 + k), 8'(8'h30 + k)};
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic report;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   task automatic cfg_wr(logic [7:0] a, logic [7:0] d);
      @(negedge cfg_clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge cfg_clk);
      wr_en = 1'b0;
      repeat (6) @(negedge smp_clk);
   endtask

   task automatic soft_pulse;
      @(negedge cfg_clk);
      soft_rst = 1'b1;
      @(negedge cfg_clk);
      soft_rst = 1'b0;
      repeat (6) @(negedge smp_clk);
   endtask

   task automatic drive_check(logic [15:0] x, logic [15:0] exp, string tag);
      @(negedge smp_clk);
      sample_in = x;
      @(negedge smp_clk);
      check(tag, data_out, exp);
   endtask

   task automatic next_out(output logic [15:0] v);
      @(negedge smp_clk);
      v = data_out;
   endtask

   initial begin
      repeat (100000) @(posedge smp_clk);
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
   end

   initial begin
      logic [15:0] v, prev;
      logic        found;

      // R3: output held at zero during reset
      repeat (3) @(negedge smp_clk);
      check("R3 in reset", data_out, 16'h0000);
      cfg_rst_n = 1'b1; smp_rst_n = 1'b1;
      repeat (4) @(negedge smp_clk);
      // R3: default coding is two's complement
      drive_check(16'h0000, 16'h8000, "R3 default coding");

      // R1 R2 R5: coding table
      for (int i = 0; i < NVEC; i++) begin
         logic [2:0] f;
         f = VEC[i][34:32];
         cfg_wr(8'h00, {5'b0, f});
         drive_check(VEC[i][31:16], VEC[i][15:0],
                     (f == 3'b000 || f == 3'b010 || f == 3'b100) ? "R1 coding" : "R2 fallback");
      end

      // Gray coding active for the test-pattern section
      cfg_wr(8'h00, 8'h02);

      // R6 R9: all ones bypasses the Gray stage
      cfg_wr(8'h01, 8'h20);
      drive_check(16'h1234, 16'hFFFF, "R9 ones bypass");
      // R6: zeros and reserved preset
      cfg_wr(8'h01, 8'h10);
      drive_check(16'hFFFF, 16'h0000, "R6 zeros");
      cfg_wr(8'h01, 8'h70);
      drive_check(16'hFFFF, 16'h0000, "R6 reserved preset");

      // R6: alternating words
      cfg_wr(8'h01, 8'h30);
      prev = '0;
      for (int i = 0; i < 4; i++) begin
         next_out(v);
         check("R6 alternating", v,
               ((v == 16'hAAAA || v == 16'h5555) && (i == 0 || v != prev)) ? v :
               (prev == 16'hAAAA ? 16'h5555 : 16'hAAAA));
         prev = v;
      end

      // R6: ramp
      cfg_wr(8'h01, 8'h40);
      next_out(prev);
      for (int i = 0; i < 5; i++) begin
         next_out(v);
         check("R6 ramp step", v, prev + 16'h0001);
         prev = v;
      end

      // R5: load user patterns byte by byte
      cfg_wr(8'h01, 8'h00);
      for (int k = 1; k <= 8; k++) begin
         cfg_wr(8'(8'h10 + 2 * (k - 1)), pat_val(k)[7:0]);
         cfg_wr(8'(8'h11 + 2 * (k - 1)), pat_val(k)[15:8]);
      end

      // R5 R7: N = 1 holds pattern 1
      cfg_wr(8'h01, 8'h01);
      for (int i = 0; i < 3; i++) begin
         next_out(v);
         check("R5 R7 single pattern", v, pat_val(1));
      end

      // R7: N = 3 cycles 1,2,3
      cfg_wr(8'h01, 8'h03);
      found = 1'b0;
      for (int i = 0; i < 10 && !found; i++) begin
         next_out(v);
         if (v == pat_val(1)) found = 1'b1;
      end
      check("R7 pattern 1 seen", {15'b0, found}, 16'h0001);
      for (int i = 0; i < 5; i++) begin
         next_out(v);
         check("R7 N=3 order", v, pat_val(((i + 1) % 3) + 1));
      end

      // R7: N = 7 cycles 1..7
      cfg_wr(8'h01, 8'h07);
      found = 1'b0;
      for (int i = 0; i < 12 && !found; i++) begin
         next_out(v);
         if (v == pat_val(1)) found = 1'b1;
      end
      for (int i = 0; i < 8; i++) begin
         next_out(v);
         check("R7 N=7 order", v, pat_val(((i + 1) % 7) + 1));
      end

      // R8: preset wins over user mode
      cfg_wr(8'h01, 8'h23);
      drive_check(16'h0000, 16'hFFFF, "R8 preset priority");

      // R4: soft reset keeps Gray, drops test mode
      soft_pulse();
      drive_check(16'h1234, 16'h1B2E, "R4 coding kept");
      // R4: pattern table cleared
      cfg_wr(8'h01, 8'h01);
      drive_check(16'h1234, 16'h0000, "R4 patterns cleared");

      // R3: power-on reset returns coding to two's complement
      @(negedge smp_clk);
      cfg_rst_n = 1'b0; smp_rst_n = 1'b0;
      repeat (3) @(negedge smp_clk);
      cfg_rst_n = 1'b1; smp_rst_n = 1'b1;
      repeat (6) @(negedge smp_clk);
      drive_check(16'h1234, 16'h9234, "R3 coding after power reset");

      report();
      $finish;
   end

endmodule